// File: doc/BRIEF.md
# Configuration Pin Interrupt Monitor

This block watches a vector of configuration handshake signals coming from a programmable fabric and turns selected changes on them into a single interrupt line for a processor. The default vector is twelve bits wide, and the bits are assigned as follows. Bit 0 is the status flag, bit 1 is config-done and bit 2 is init-done. Bit 3 is the CRC error. Bit 4 is the alternate config-done, and bits 5, 6 and 7 are partial-reconfiguration ready, error and done. Bit 8 is the config-request pin, bit 9 the status pin, bit 10 the config-done pin, and bit 11 is fabric power-on. Every per-bit register uses this layout, so bit n of each register refers to the same signal.

Each input first passes through a synchroniser. For each bit, software then picks whether the source is enabled, whether it triggers on a level or on an edge, which polarity counts as active, and whether it is masked from the interrupt. Software can read the pre-mask (raw) status, the post-mask status and the synchronised pin values directly. Edge-latched bits are cleared by writing ones to an end-of-interrupt register. The register port is a simple single-cycle write strobe with a combinational read mux selected by a 3-bit word address.

Top module: `cfg_pin_irq_mon`

## Requirements
- R1: Each pin reaches the port register (address 7) through exactly two flip-flops, so a pin value becomes readable after the second rising clock edge that samples it.
- R2: All reads return the 12 monitored bits in positions 11..0, and bits 31..12 always read as zero.
- R3: A bit whose enable (address 0) is 0 contributes nothing to raw or masked status. Clearing the enable bit discards any edge already latched for that bit, and setting it again does not bring the latched edge back.
- R4: When the trigger-type bit (address 2) is 0, the bit is level-triggered: its raw status (address 5) equals the active level of the synchronised pin. Polarity (address 3) of 1 means the active level is high; 0 means it is low.
- R5: A level-triggered bit stays set in raw status after an end-of-interrupt write for as long as its input remains active.
- R6: When the trigger-type bit is 1, the bit is edge-triggered. A transition into the active level (a rising edge for polarity 1, a falling edge for polarity 0) latches the raw bit, which then appears on the third clock edge after the pin changes. The latched bit remains set after the pin goes back to inactive.
- R7: Writing to the end-of-interrupt register (address 6) clears each latched edge bit written as 1 and leaves bits written as 0 untouched. If a new edge arrives in the same cycle as the clear, the bit stays set. This register always reads as zero.
- R8: Masked status (address 4) is raw status with every bit cleared whose mask bit (address 1) is 1.
- R9: The interrupt output is high exactly when at least one bit of masked status is set.
- R10: The four configuration registers (addresses 0 to 3) read back the low 12 bits last written to them. Writes to addresses 4, 5 and 7 have no effect.
- R11: After reset, every configuration register, every status register and the interrupt output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 12 | Asynchronous configuration handshake signals |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
Results arrive with fixed delays. A level source shows up in status two clock edges after its pin changes. An edge source shows up three edges after the pin changes, because the edge is latched one stage behind the synchroniser. A register write or an end-of-interrupt clear takes effect on the edge that samples it, and reads respond combinationally in the same cycle. The bench model shifts the pins through three history slots and updates its latches at each rising edge. It then compares read data and the interrupt on the following falling edge. The directed checks wait exactly two or three edges before sampling, which catches a synchroniser or latch that is one stage too short or too long.

// File: rtl/cfgmon_pkg.sv
package cfgmon_pkg;
   localparam int unsigned SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      REG_ENABLE = 3'd0,
      REG_MASK   = 3'd1,
      REG_TRIG   = 3'd2,
      REG_POL    = 3'd3,
      REG_MSTAT  = 3'd4,
      REG_RSTAT  = 3'd5,
      REG_EOI    = 3'd6,
      REG_PORT   = 3'd7
   } reg_sel_e;
endpackage

// File: rtl/cfgmon_sync.sv
module cfgmon_sync #(
   parameter int unsigned WIDTH  = 12,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[0] <= '0;
            else        stg_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfgmon_detect.sv
module cfgmon_detect #(
   parameter int unsigned NBITS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] sync_i,
   input  logic [NBITS-1:0] en_i,
   input  logic [NBITS-1:0] typ_i,
   input  logic [NBITS-1:0] pol_i,
   input  logic [NBITS-1:0] eoi_i,
   output logic [NBITS-1:0] raw_o,
   output logic [NBITS-1:0] evt_o,
   output logic [NBITS-1:0] lat_o
);
   logic [NBITS-1:0] prv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv_q <= '0;
      else        prv_q <= sync_i;
   end

   for (genvar b = 0; b < NBITS; b++) begin : g_bit
      logic act_now;
      logic act_prv;
      logic hit;
      logic lat_q;

      assign act_now = pol_i[b] ? sync_i[b] : ~sync_i[b];
      assign act_prv = pol_i[b] ? prv_q[b]  : ~prv_q[b];
      assign hit     = act_now & ~act_prv;

      // set wins over a simultaneous clear so a fresh edge is never lost
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lat_q <= 1'b0;
         else        lat_q <= en_i[b] & typ_i[b] & (hit | (lat_q & ~eoi_i[b]));
      end

      assign raw_o[b] = en_i[b] & (typ_i[b] ? lat_q : act_now);
      assign evt_o[b] = hit;
      assign lat_o[b] = lat_q;
   end
endmodule

// File: rtl/cfgmon_regs.sv
module cfgmon_regs
   import cfgmon_pkg::*;
#(
   parameter int unsigned NBITS  = 12,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [SEL_W-1:0]  addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [NBITS-1:0]  raw_i,
   input  logic [NBITS-1:0]  sync_i,
   output logic [NBITS-1:0]  en_o,
   output logic [NBITS-1:0]  msk_o,
   output logic [NBITS-1:0]  typ_o,
   output logic [NBITS-1:0]  pol_o,
   output logic [NBITS-1:0]  eoi_o,
   output logic [NBITS-1:0]  mstat_o,
   output logic [DATA_W-1:0] rdata_o
);
   reg_sel_e         sel;
   logic [NBITS-1:0] wbits;
   logic [NBITS-1:0] rd_bits;
   logic             unused_wdata;

   assign sel          = reg_sel_e'(addr_i);
   assign wbits        = wdata_i[NBITS-1:0];
   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o  <= '0;
         msk_o <= '0;
         typ_o <= '0;
         pol_o <= '0;
      end else if (wr_en_i) begin
         case (sel)
            REG_ENABLE: en_o  <= wbits;
            REG_MASK:   msk_o <= wbits;
            REG_TRIG:   typ_o <= wbits;
            REG_POL:    pol_o <= wbits;
            default: ;
         endcase
      end
   end

   assign eoi_o   = (wr_en_i && sel == REG_EOI) ? wbits : '0;
   assign mstat_o = raw_i & ~msk_o;

   always_comb begin
      case (sel)
         REG_ENABLE: rd_bits = en_o;
         REG_MASK:   rd_bits = msk_o;
         REG_TRIG:   rd_bits = typ_o;
         REG_POL:    rd_bits = pol_o;
         REG_MSTAT:  rd_bits = mstat_o;
         REG_RSTAT:  rd_bits = raw_i;
         REG_PORT:   rd_bits = sync_i;
         default:    rd_bits = '0;
      endcase
   end

   assign rdata_o = DATA_W'(rd_bits);
endmodule

// File: rtl/cfg_pin_irq_mon.sv
module cfg_pin_irq_mon
   import cfgmon_pkg::*;
#(
   parameter int unsigned NBITS       = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NBITS-1:0]  pins_i,
   input  logic              wr_en_i,
   input  logic [SEL_W-1:0]  addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   if (NBITS < 1 || NBITS > DATA_W) begin : g_bad_width
      $error("cfg_pin_irq_mon: NBITS must lie in 1..DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cfg_pin_irq_mon: SYNC_STAGES must be at least 2");
   end

   logic [NBITS-1:0] sync_q;
   logic [NBITS-1:0] en_q, msk_q, typ_q, pol_q;
   logic [NBITS-1:0] eoi_clr;
   logic [NBITS-1:0] raw_st, mstat;
   logic [NBITS-1:0] edge_evt, edge_lat;

   cfgmon_sync #(.WIDTH(NBITS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_i),
      .q_o   (sync_q)
   );

   cfgmon_detect #(.NBITS(NBITS)) i_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (sync_q),
      .en_i   (en_q),
      .typ_i  (typ_q),
      .pol_i  (pol_q),
      .eoi_i  (eoi_clr),
      .raw_o  (raw_st),
      .evt_o  (edge_evt),
      .lat_o  (edge_lat)
   );

   cfgmon_regs #(.NBITS(NBITS), .DATA_W(DATA_W)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (wr_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .raw_i   (raw_st),
      .sync_i  (sync_q),
      .en_o    (en_q),
      .msk_o   (msk_q),
      .typ_o   (typ_q),
      .pol_o   (pol_q),
      .eoi_o   (eoi_clr),
      .mstat_o (mstat),
      .rdata_o (rdata_o)
   );

   assign irq_o = |mstat;
endmodule

// File: rtl/cfg_pin_irq_mon_chk.sv
module cfg_pin_irq_mon_chk #(
   parameter int unsigned NBITS       = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NBITS-1:0]  pins_i,
   input logic              wr_en_i,
   input logic [2:0]        addr_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              irq_o,
   input logic [NBITS-1:0]  sync_q,
   input logic [NBITS-1:0]  edge_evt,
   input logic [NBITS-1:0]  edge_lat,
   input logic [NBITS-1:0]  raw_st,
   input logic [NBITS-1:0]  en_q,
   input logic [NBITS-1:0]  msk_q,
   input logic [NBITS-1:0]  typ_q,
   input logic [NBITS-1:0]  pol_q,
   input logic [NBITS-1:0]  eoi_clr
);
   logic [1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   if (SYNC_STAGES == 2) begin : g_two_stage
      p_sync_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (age >= 2'd2) |-> (sync_q == $past(pins_i, 2)));
   end

   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_o >> NBITS) == '0);

   p_disable_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1) |-> ((edge_lat & ~$past(en_q)) == '0));

   p_latch_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1) |-> ((edge_lat & ~$past(edge_lat) & ~$past(edge_evt)) == '0));

   p_eoi_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1) |-> ((edge_lat & $past(eoi_clr) & ~$past(edge_evt)) == '0));

   p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (raw_st != '0));

   p_ro_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i >= 3'd4 && addr_i != 3'd6) |=>
      ($stable(en_q) && $stable(msk_q) && $stable(typ_q) && $stable(pol_q)));
endmodule

bind cfg_pin_irq_mon cfg_pin_irq_mon_chk #(
   .NBITS(NBITS), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) i_chk (.*);

// File: tb/test_cfg_pin_irq_mon.sv
module test_cfg_pin_irq_mon;
   localparam int NB = 12;
   localparam int DW = 32;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] pins  = '0;
   logic          wr    = 1'b0;
   logic [2:0]    addr  = '0;
   logic [DW-1:0] wdata = '0;
   wire  [DW-1:0] rdata;
   wire           irq;

   always #4 clk = ~clk;

   cfg_pin_irq_mon i_cfg_pin_irq_mon (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en_i(wr),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   // behavioural reference: pin history and register images
   logic [NB-1:0] m_d1, m_d2, m_d3, m_en, m_msk, m_typ, m_pol, m_lat;

   function automatic logic [NB-1:0] m_raw();
      logic [NB-1:0] r;
      for (int b = 0; b < NB; b++) begin
         if (!m_en[b])      r[b] = 1'b0;
         else if (m_typ[b]) r[b] = m_lat[b];
         else               r[b] = m_pol[b] ? m_d2[b] : !m_d2[b];
      end
      return r;
   endfunction

   function automatic logic [DW-1:0] m_read(logic [2:0] a);
      logic [NB-1:0] v;
      case (a)
         3'd0: v = m_en;
         3'd1: v = m_msk;
         3'd2: v = m_typ;
         3'd3: v = m_pol;
         3'd4: v = m_raw() & ~m_msk;
         3'd5: v = m_raw();
         3'd7: v = m_d2;
         default: v = '0;
      endcase
      return DW'(v);
   endfunction

   function automatic string req_of(logic [2:0] a);
      case (a)
         3'd4:    return "R8";
         3'd5:    return "R4";
         3'd7:    return "R1";
         default: return "R10";
      endcase
   endfunction

   task automatic model_reset();
      m_d1 = '0; m_d2 = '0; m_d3 = '0; m_en = '0;
      m_msk = '0; m_typ = '0; m_pol = '0; m_lat = '0;
   endtask

   task automatic model_step();
      logic [NB-1:0] clr, nl;
      bit evt;
      clr = (wr && addr == 3'd6) ? wdata[NB-1:0] : '0;
      for (int b = 0; b < NB; b++) begin
         evt   = m_pol[b] ? (m_d2[b] && !m_d3[b]) : (!m_d2[b] && m_d3[b]);
         nl[b] = m_en[b] && m_typ[b] && (evt || (m_lat[b] && !clr[b]));
      end
      if (wr) begin
         case (addr)
            3'd0: m_en  = wdata[NB-1:0];
            3'd1: m_msk = wdata[NB-1:0];
            3'd2: m_typ = wdata[NB-1:0];
            3'd3: m_pol = wdata[NB-1:0];
            default: ;
         endcase
      end
      m_lat = nl;
      m_d3 = m_d2; m_d2 = m_d1; m_d1 = pins;
   endtask

   task automatic chk(logic [DW-1:0] act, logic [DW-1:0] exp, string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(rdata, m_read(addr), req_of(addr));
      chk(DW'(irq), DW'(|(m_raw() & ~m_msk)), "R9");
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr_reg(logic [2:0] a, logic [DW-1:0] d);
      addr = a; wdata = d; wr = 1'b1;
      tick();
      wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [DW-1:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   logic [DW-1:0] v;

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: reset state of every register and the interrupt
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         chk(v, 32'h0, "R11");
      end
      chk(DW'(irq), 32'h0, "R11");

      // R1: two-flop path to the port register
      pins = 12'hA5C;
      tick();
      rd(3'd7, v); chk(v, 32'h0, "R1");
      tick();
      rd(3'd7, v); chk(v, 32'h0000_0A5C, "R1");

      // R10 / R2: writes to read-only ignored, upper bits zero
      wr_reg(3'd7, 32'hFFFF_FFFF);
      rd(3'd7, v); chk(v, 32'h0000_0A5C, "R10");
      wr_reg(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, v); chk(v, 32'h0000_0FFF, "R2");
      wr_reg(3'd0, 32'h0);
      wr_reg(3'd5, 32'hFFFF_FFFF);
      wr_reg(3'd4, 32'hFFFF_FFFF);
      rd(3'd0, v); chk(v, 32'h0, "R10");
      rd(3'd1, v); chk(v, 32'h0, "R10");
      rd(3'd6, v); chk(v, 32'h0, "R7");

      // R4: level sources with both polarities
      pins = '0;
      ticks(2);
      wr_reg(3'd3, 32'h001);
      wr_reg(3'd0, 32'h003);
      rd(3'd5, v); chk(v, 32'h002, "R4");
      chk(DW'(irq), 32'h1, "R9");
      pins = 12'h001;
      ticks(2);
      rd(3'd5, v); chk(v, 32'h003, "R4");
      pins = '0;
      ticks(2);
      rd(3'd5, v); chk(v, 32'h002, "R4");

      // R8: mask
      wr_reg(3'd1, 32'h002);
      rd(3'd4, v); chk(v, 32'h0, "R8");
      chk(DW'(irq), 32'h0, "R8");
      rd(3'd5, v); chk(v, 32'h002, "R8");
      wr_reg(3'd1, 32'h0);
      rd(3'd4, v); chk(v, 32'h002, "R8");

      // R5: level stays pending after end-of-interrupt
      wr_reg(3'd6, 32'hFFF);
      rd(3'd5, v); chk(v, 32'h002, "R5");
      chk(DW'(irq), 32'h1, "R5");
      wr_reg(3'd0, 32'h0);
      rd(3'd5, v); chk(v, 32'h0, "R3");
      chk(DW'(irq), 32'h0, "R3");

      // R6: rising edge on bit 4, falling edge on bit 5
      wr_reg(3'd3, 32'h010);
      wr_reg(3'd2, 32'h030);
      wr_reg(3'd0, 32'h030);
      pins = 12'h010;
      ticks(2);
      rd(3'd5, v); chk(v, 32'h0, "R6");
      tick();
      rd(3'd5, v); chk(v, 32'h010, "R6");
      pins = '0;
      ticks(3);
      rd(3'd5, v); chk(v, 32'h010, "R6");

      // R7: end-of-interrupt clears only written bits
      wr_reg(3'd6, 32'h020);
      rd(3'd5, v); chk(v, 32'h010, "R7");
      wr_reg(3'd6, 32'h010);
      rd(3'd5, v); chk(v, 32'h0, "R7");

      pins = 12'h020;
      ticks(3);
      rd(3'd5, v); chk(v, 32'h0, "R6");
      pins = '0;
      ticks(2);
      rd(3'd5, v); chk(v, 32'h0, "R6");
      tick();
      rd(3'd5, v); chk(v, 32'h020, "R6");
      wr_reg(3'd6, 32'h020);

      // R7: new edge in the same cycle as the clear keeps the bit
      pins = 12'h010;
      ticks(2);
      wr_reg(3'd6, 32'h010);
      rd(3'd5, v); chk(v, 32'h010, "R7");

      // R3: disabling drops the latched edge for good
      wr_reg(3'd0, 32'h020);
      rd(3'd5, v); chk(v, 32'h0, "R3");
      wr_reg(3'd0, 32'h030);
      rd(3'd5, v); chk(v, 32'h0, "R3");

      // R9: interrupt is the OR of masked bits
      wr_reg(3'd2, 32'h0);
      wr_reg(3'd3, 32'h0);
      wr_reg(3'd0, 32'h003);
      rd(3'd5, v); chk(v, 32'h003, "R4");
      chk(DW'(irq), 32'h1, "R9");
      wr_reg(3'd1, 32'h001);
      chk(DW'(irq), 32'h1, "R9");
      wr_reg(3'd1, 32'h003);
      chk(DW'(irq), 32'h0, "R9");
      rd(3'd4, v); chk(v, 32'h0, "R8");

      // mixed random traffic against the model
      for (int i = 0; i < 600; i++) begin
         if ($urandom_range(3) == 0) pins = pins ^ NB'($urandom);
         addr  = 3'($urandom);
         wdata = $urandom;
         wr    = ($urandom_range(3) == 0);
         tick();
         wr = 1'b0;
      end

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog R11 actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule